// File: doc/BRIEF.md
# Serial-Programmed Clock Fanout Controller

This block holds the configuration logic of a one-to-ten clock fanout buffer. A mode input picks one of two behaviours. In programmable mode a serial data input is clocked into an eleven-stage shift register, one bit per rising edge of a dedicated shift clock. The edge after the eleventh shift commits the word to a control register. That register sets, for each of the ten outputs, whether it toggles or is held off, and it picks which of two candidate clocks feeds the outputs. In standard mode the register plays no part: every output is on and the serial data pin chooses the clock directly.

After a commit the control register is locked. It takes no new word until a shift-clock edge arrives with the mode input low, which clears the shift register, the edge counter, the lock flag and the control register. The output stage is modelled as plain logic. An enabled pair carries the chosen clock on its true line and its inverse on the complement line. A disabled pair rests with the true line low and the complement line high. An asynchronous power-on reset sets the same state as a mode-low edge.

Top module: `fanout_cfg_top`

## Requirements
- R1: With `en` high and the register not locked, each rising `ck` edge shifts `si` into the shift register. The first bit received becomes word bit 0 and the eleventh becomes bit 10.
- R2: The control register is written on the twelfth rising `ck` edge with `en` high after a reset, and on no earlier edge. Until that write, programmable mode shows the register's reset value: all ten outputs enabled and CLK0 selected.
- R3: Word bit k, for k from 0 to 9, enables output 9-k. A bit value of 1 enables the output and 0 disables it.
- R4: Word bit 10 selects the input clock: 0 selects `clk0` (`clk_sel`=0) and 1 selects `clk1` (`clk_sel`=1).
- R5: Once the register has been written, further rising `ck` edges with `en` high leave it unchanged until a reset.
- R6: A rising `ck` edge with `en` low clears the shift register and the edge counter, unlocks the register and returns it to its reset value. This also aborts a partial load, and a full load after it succeeds.
- R7: While `en` is low, all ten `out_en` bits are 1 and `clk_sel` follows `si` directly (0 gives `clk0`, 1 gives `clk1`).
- R8: An enabled output drives `q_p` with the selected clock and `q_n` with its inverse. A disabled output drives `q_p` low and `q_n` high.
- R9: While `rst_n` is low, the state is held at its reset value, so that with `en` high all outputs are enabled and CLK0 is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| ck | input | 1 | Shift clock; rising edges shift, commit or reset |
| en | input | 1 | Mode: 1 programmable, 0 standard |
| si | input | 1 | Serial data in programmable mode, clock select in standard mode |
| clk0 | input | 1 | First candidate clock |
| clk1 | input | 1 | Second candidate clock |
| out_en | output | 10 | Effective per-output enable, index = output number |
| clk_sel | output | 1 | Effective input clock select (0 = clk0, 1 = clk1) |
| q_p | output | 10 | True line of each output pair |
| q_n | output | 10 | Complement line of each output pair |

## Verification
The hardest states to reach are those that depend on the count of edges since the last mode-low edge. These are the exact edge on which the commit lands, the locked state that rejects a second word, and an abort partway through a load. Each of them is invisible at the ports until the commit edge or a reset exposes it. The stimulus therefore counts edges itself. Every load begins with a mode-low edge, the outputs are sampled after the eleventh shift and again after the twelfth edge, a second word is pushed into a locked register, and a half-shifted word is cut off by a mode-low edge before a clean load.

// File: rtl/fanout_cfg_pkg.sv
package fanout_cfg_pkg;

   // Source clock encoding used for the select bit of the word
   typedef enum logic {
      SRC_CLK0 = 1'b0,
      SRC_CLK1 = 1'b1
   } clk_src_e;

   // Width of the edge counter needed to reach the commit edge
   function automatic int unsigned cnt_width(input int unsigned n_out);
      return $clog2(n_out + 2);
   endfunction

endpackage

// File: rtl/fanout_cfg_shifter.sv
module fanout_cfg_shifter #(
   parameter int unsigned N_OUT = 10
) (
   input  logic             rst_n,
   input  logic             ck,
   input  logic             en,
   input  logic             si,
   output logic [N_OUT:0]   ctrl,
   output logic             locked
);
   import fanout_cfg_pkg::*;

   localparam int unsigned WORD_W = N_OUT + 1;
   localparam int unsigned CNT_W  = cnt_width(N_OUT);
   localparam logic [CNT_W-1:0] CNT_COMMIT = CNT_W'(WORD_W);
   localparam logic [WORD_W-1:0] CTRL_RST = {SRC_CLK0, {N_OUT{1'b1}}};

   initial begin
      if (N_OUT < 1) $error("N_OUT must be at least 1");
      if ((1 << CNT_W) <= WORD_W) $error("edge counter too narrow");
   end

   logic [WORD_W-1:0] shreg;
   logic [CNT_W-1:0]  cnt;

   always_ff @(posedge ck or negedge rst_n) begin
      if (!rst_n) begin
         shreg  <= '0;
         cnt    <= '0;
         ctrl   <= CTRL_RST;
         locked <= 1'b0;
      end else if (!en) begin
         shreg  <= '0;
         cnt    <= '0;
         ctrl   <= CTRL_RST;
         locked <= 1'b0;
      end else if (!locked) begin
         if (cnt != CNT_COMMIT) begin
            // first received bit travels down to position 0
            shreg <= {si, shreg[WORD_W-1:1]};
            cnt   <= cnt + 1'b1;
         end else begin
            ctrl   <= shreg;
            locked <= 1'b1;
         end
      end
   end

   // R6
   mode_low_clears_chk: assert property (@(posedge ck) disable iff (!rst_n)
      !en |=> (cnt == '0 && !locked && ctrl == CTRL_RST));

   // R2
   commit_on_last_edge_chk: assert property (@(posedge ck) disable iff (!rst_n)
      $rose(locked) |-> $past(cnt) == CNT_COMMIT);

   // R5
   second_load_ignored_chk: assert property (@(posedge ck) disable iff (!rst_n)
      (en && locked) |=> $stable(ctrl));

   // R1
   cnt_bound_chk: assert property (@(posedge ck) disable iff (!rst_n)
      cnt <= CNT_COMMIT);

endmodule

// File: rtl/fanout_cfg_mode_mux.sv
module fanout_cfg_mode_mux #(
   parameter int unsigned N_OUT = 10
) (
   input  logic             en,
   input  logic             si,
   input  logic [N_OUT:0]   ctrl,
   output logic [N_OUT-1:0] out_en,
   output logic             clk_sel
);
   // select bit sits above the enable bits
   assign clk_sel = en ? ctrl[N_OUT] : si;

   // word bit k drives output N_OUT-1-k
   for (genvar j = 0; j < N_OUT; j++) begin : g_map
      assign out_en[j] = en ? ctrl[N_OUT-1-j] : 1'b1;
   end

endmodule

// File: rtl/fanout_gate_bank.sv
module fanout_gate_bank #(
   parameter int unsigned N_OUT = 10
) (
   input  logic             clk0,
   input  logic             clk1,
   input  logic             clk_sel,
   input  logic [N_OUT-1:0] out_en,
   output logic [N_OUT-1:0] q_p,
   output logic [N_OUT-1:0] q_n
);
   logic src;
   assign src = clk_sel ? clk1 : clk0;

   for (genvar j = 0; j < N_OUT; j++) begin : g_pair
      assign q_p[j] = out_en[j] & src;
      assign q_n[j] = ~(out_en[j] & src);
   end

endmodule

// File: rtl/fanout_cfg_top.sv
module fanout_cfg_top #(
   parameter int unsigned N_OUT = 10
) (
   input  logic             rst_n,
   input  logic             ck,
   input  logic             en,
   input  logic             si,
   input  logic             clk0,
   input  logic             clk1,
   output logic [N_OUT-1:0] out_en,
   output logic             clk_sel,
   output logic [N_OUT-1:0] q_p,
   output logic [N_OUT-1:0] q_n
);
   logic [N_OUT:0] ctrl;
   logic           locked;

   fanout_cfg_shifter #(.N_OUT(N_OUT)) u_shift (
      .rst_n (rst_n),
      .ck    (ck),
      .en    (en),
      .si    (si),
      .ctrl  (ctrl),
      .locked(locked)
   );

   fanout_cfg_mode_mux #(.N_OUT(N_OUT)) u_mux (
      .en     (en),
      .si     (si),
      .ctrl   (ctrl),
      .out_en (out_en),
      .clk_sel(clk_sel)
   );

   fanout_gate_bank #(.N_OUT(N_OUT)) u_gate (
      .clk0   (clk0),
      .clk1   (clk1),
      .clk_sel(clk_sel),
      .out_en (out_en),
      .q_p    (q_p),
      .q_n    (q_n)
   );

   // R7
   std_mode_all_on_chk: assert property (@(posedge ck) disable iff (!rst_n)
      !en |-> (&out_en));

   // R8
   disabled_pair_rest_chk: assert property (@(posedge ck) disable iff (!rst_n)
      (((~out_en) & q_p) == '0) && (((~out_en) & ~q_n) == '0));

endmodule

// File: tb/test_fanout_cfg_top.sv
module test_fanout_cfg_top;

   logic       rst_n, ck, en, si, clk0, clk1;
   logic [9:0] out_en, q_p, q_n;
   logic       clk_sel;
   int         n_run = 0;
   int         n_fail = 0;
   bit         done = 0;

   fanout_cfg_top i_fanout_cfg_top (
      .rst_n(rst_n), .ck(ck), .en(en), .si(si), .clk0(clk0), .clk1(clk1),
      .out_en(out_en), .clk_sel(clk_sel), .q_p(q_p), .q_n(q_n)
   );

   initial ck = 1'b0;
   always #4 ck = ~ck;

   // {word[10:0], expected out_en[9:0], expected clk_sel}
   localparam logic [21:0] VEC [0:5] = '{
      {11'h001, 10'h200, 1'b0},
      {11'h200, 10'h001, 1'b0},
      {11'h400, 10'h000, 1'b1},
      {11'h7FF, 10'h3FF, 1'b1},
      {11'h155, 10'h2AA, 1'b0},
      {11'h0F0, 10'h03C, 1'b0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic edge_with(input logic en_v, input logic si_v);
      @(negedge ck);
      en = en_v;
      si = si_v;
      @(posedge ck);
      #2;
   endtask

   task automatic check_gates(input logic [9:0] en_exp, input logic sel_exp);
      logic src;
      for (int p = 0; p < 2; p++) begin
         clk0 = (p == 0);
         clk1 = (p != 0);
         #1;
         src = sel_exp ? clk1 : clk0;
         check("R8 q_p", {22'd0, q_p}, {22'd0, en_exp & {10{src}}});
         check("R8 q_n", {22'd0, q_n}, {22'd0, ~(en_exp & {10{src}})});
      end
   endtask

   task automatic load_word(input logic [10:0] w, input logic do_checks);
      for (int i = 0; i < 11; i++) edge_with(1'b1, w[i]);
      if (do_checks) begin
         check("R2 pre-commit out_en", {22'd0, out_en}, 32'h3FF);
         check("R2 pre-commit clk_sel", {31'd0, clk_sel}, 32'd0);
      end
      edge_with(1'b1, 1'b0);
   endtask

   initial begin
      rst_n = 1'b0; en = 1'b1; si = 1'b0; clk0 = 1'b0; clk1 = 1'b0;
      repeat (3) @(posedge ck);
      #2;
      // R9 reset value seen while held in reset
      check("R9 out_en", {22'd0, out_en}, 32'h3FF);
      check("R9 clk_sel", {31'd0, clk_sel}, 32'd0);
      @(negedge ck);
      rst_n = 1'b1;

      // table walk: R1 R3 R4 R6 (reconfigure after mode-low reset)
      for (int v = 0; v < 6; v++) begin
         logic [10:0] w;
         logic [9:0]  e;
         logic        s;
         {w, e, s} = VEC[v];
         edge_with(1'b0, 1'b0);
         load_word(w, 1'b1);
         check("R3 out_en", {22'd0, out_en}, {22'd0, e});
         check("R4 clk_sel", {31'd0, clk_sel}, {31'd0, s});
         check_gates(e, s);
      end

      // R5: a second word after commit is ignored
      edge_with(1'b0, 1'b0);
      load_word(11'h001, 1'b0);
      load_word(11'h7FF, 1'b0);
      for (int k = 0; k < 5; k++) edge_with(1'b1, 1'b1);
      check("R5 out_en", {22'd0, out_en}, 32'h200);
      check("R5 clk_sel", {31'd0, clk_sel}, 32'd0);

      // R6: abort a partial load, then reload cleanly
      for (int k = 0; k < 5; k++) edge_with(1'b1, 1'b1);
      edge_with(1'b0, 1'b0);
      for (int k = 0; k < 5; k++) edge_with(1'b1, 1'b1);
      check("R6 partial out_en", {22'd0, out_en}, 32'h3FF);
      edge_with(1'b0, 1'b0);
      load_word(11'h40F, 1'b1);
      check("R6 reload out_en", {22'd0, out_en}, 32'h3C0);
      check("R6 reload clk_sel", {31'd0, clk_sel}, 32'd1);

      // R7: standard mode, si selects the clock directly
      @(negedge ck);
      en = 1'b0; si = 1'b1; #1;
      check("R7 out_en", {22'd0, out_en}, 32'h3FF);
      check("R7 sel si=1", {31'd0, clk_sel}, 32'd1);
      check_gates(10'h3FF, 1'b1);
      si = 1'b0; #1;
      check("R7 sel si=0", {31'd0, clk_sel}, 32'd0);
      check_gates(10'h3FF, 1'b0);

      // R9: async reset mid-configuration
      edge_with(1'b0, 1'b0);
      load_word(11'h000, 1'b0);
      check("R3 all off", {22'd0, out_en}, 32'h000);
      @(negedge ck);
      rst_n = 1'b0; #1;
      check("R9 async out_en", {22'd0, out_en}, 32'h3FF);
      rst_n = 1'b1;

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule